// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models the slave side of an 8 Kbit serial EEPROM with a three-wire interface. The chip select, serial clock and data input are oversampled by the system clock. A frame opens with a start bit, which is followed by a two-bit opcode, an address and, for writes, a data word. The block then reads, writes or erases one word, fills or erases the whole array, or sets and clears a write-enable latch. During programming, a busy/ready status appears on the data output.

The organization input chooses 16-bit words (high) or 8-bit words (low) over the same byte storage. The program-enable input can block every modifying instruction. The data output comes with a separate enable, so the pad can be made high-impedance. Programming time is a parameter counted in system clock cycles.

Top module: `serial_eeprom`

## Requirements
- R1: A frame starts only at the first serial clock rising edge where chip select and data input are both high. Rising edges with data input low, and any activity while chip select is low, start nothing.
- R2: After the start bit come a 2-bit opcode (10 read, 01 write, 11 erase, 00 extended) and the address, both MSB first. The address is 10 bits in x8 mode and 9 bits in x16 mode. In the extended group, the two most significant address bits select 11 write-enable, 00 write-disable, 10 erase-all and 01 write-all.
- R3: A read drives a dummy 0 after the last address bit. Each following rising edge then presents one data bit, MSB first. The rising edge after the last data bit releases the output.
- R4: A write stores the data word that follows the address: 16 bits in x16 mode, 8 bits in x8 mode. In x16 mode, word a occupies byte 2a+1 (high byte) and byte 2a (low byte), as seen in x8 mode.
- R5: Erase sets every bit of the addressed word to one.
- R6: Write-all stores the supplied word at every address. Erase-all sets every word to all ones.
- R7: After reset the block is write-disabled. A write, erase, write-all or erase-all takes effect only after a write-enable, and write-disable blocks them again.
- R8: While program enable is low, every write, erase, write-all and erase-all is blocked.
- R9: A frame cut short by chip select falling before its last required bit is discarded.
- R10: After an accepted modifying instruction, the output is driven low for PROG_CYCLES system cycles while chip select is high. It is then driven high until chip select falls.
- R11: Serial activity during the programming window has no effect.
- R12: The output enable is low whenever chip select is low, and also outside a read shift or a status display.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | Organization: 1 = 512 x 16, 0 = 1024 x 8 |
| pe_i | input | 1 | Program enable, low blocks all modifications |
| do_o | output | 1 | Serial data / ready-busy out |
| do_oe_o | output | 1 | Output enable for do_o |

## Verification
The checker assumes that the serial pins change slowly compared with the system clock, so that every serial clock phase spans several system cycles. It also assumes that organization and program enable are held steady for the length of a frame. The bench holds each serial clock phase for four system cycles. It changes data input only while the serial clock is low, and changes organization or program enable only between frames with chip select low.

// File: rtl/se_pkg.sv
package se_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_PROG, ST_STATUS, ST_DONE
  } st_e;

  typedef enum logic [1:0] {AOP_NONE, AOP_WORD, AOP_ALL} aop_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] EX_WDIS  = 2'b00;
  localparam logic [1:0] EX_WRALL = 2'b01;
  localparam logic [1:0] EX_ERALL = 2'b10;
  localparam logic [1:0] EX_WEN   = 2'b11;
endpackage

// File: rtl/se_sync.sv
module se_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/se_busy_timer.sv
module se_busy_timer #(
  parameter int CYCLES = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (start_i) cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1)) && !start_i;
endmodule

// File: rtl/se_array.sv
module se_array
  import se_pkg::*;
#(
  parameter int BYTES = 1024,
  parameter int AW    = $clog2(BYTES)
) (
  input  logic          clk_i,
  input  logic          org_i,
  input  aop_e          op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   wdata_i,
  output logic [15:0]   rdata_o
);
  localparam int WAW = AW - 1;

  logic [7:0]    mem [BYTES];
  logic [AW-1:0] lo_idx, hi_idx;

  assign lo_idx = org_i ? {addr_i[WAW-1:0], 1'b0} : addr_i;
  assign hi_idx = {addr_i[WAW-1:0], 1'b1};

  always_ff @(posedge clk_i) begin
    unique case (op_i)
      AOP_WORD: begin
        mem[lo_idx] <= wdata_i[7:0];
        if (org_i) mem[hi_idx] <= wdata_i[15:8];
      end
      AOP_ALL: begin
        for (int i = 0; i < BYTES; i++)
          mem[i] <= (org_i && i[0]) ? wdata_i[15:8] : wdata_i[7:0];
      end
      default: ;
    endcase
  end

  assign rdata_o = org_i ? {mem[hi_idx], mem[lo_idx]} : {8'h00, mem[lo_idx]};
endmodule

// File: rtl/se_ctrl.sv
module se_ctrl
  import se_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rise_i,
  input  logic          di_i,
  input  logic          org_i,
  input  logic          pe_i,
  input  logic          done_i,
  input  logic [15:0]   rdata_i,
  output aop_e          aop_o,
  output logic [AW-1:0] addr_o,
  output logic [15:0]   wdata_o,
  output logic          start_o,
  output logic          wen_o,
  output st_e           st_o,
  output logic          do_o,
  output logic          do_oe_o
);
  localparam logic [4:0] ALEN8  = 5'(AW);
  localparam logic [4:0] ALEN16 = 5'(AW - 1);

  st_e           st_q;
  aop_e          aop_q;
  logic [1:0]    opc_q;
  logic [AW-1:0] addr_q, addr_nxt;
  logic [15:0]   data_q, data_nxt, wdata_q, rd_sr_q;
  logic [4:0]    cnt_q, alen, dlen;
  logic          wen_q, out_q, start_q, prog_ok;
  logic [1:0]    ext;

  assign alen     = org_i ? ALEN16 : ALEN8;
  assign dlen     = org_i ? 5'd16 : 5'd8;
  assign addr_nxt = {addr_q[AW-2:0], di_i};
  assign data_nxt = {data_q[14:0], di_i};
  assign ext      = org_i ? addr_nxt[AW-2 -: 2] : addr_nxt[AW-1 -: 2];
  assign prog_ok  = wen_q && pe_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      aop_q   <= AOP_NONE;
      opc_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      wdata_q <= '0;
      rd_sr_q <= '0;
      cnt_q   <= '0;
      wen_q   <= 1'b0;
      out_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      aop_q   <= AOP_NONE;
      start_q <= 1'b0;
      if (!cs_i && st_q != ST_PROG) begin
        st_q <= ST_IDLE;
      end else begin
        unique case (st_q)
          ST_IDLE: if (rise_i && di_i) begin
            st_q   <= ST_OPC;
            cnt_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
          end
          ST_OPC: if (rise_i) begin
            opc_q <= {opc_q[0], di_i};
            if (cnt_q == 5'd1) begin
              cnt_q <= '0;
              st_q  <= ST_ADDR;
            end else cnt_q <= cnt_q + 5'd1;
          end
          ST_ADDR: if (rise_i) begin
            addr_q <= addr_nxt;
            if (cnt_q == alen - 5'd1) begin
              cnt_q <= '0;
              unique case (opc_q)
                OP_READ: begin
                  rd_sr_q <= org_i ? rdata_i : {rdata_i[7:0], 8'h00};
                  out_q   <= 1'b0;
                  cnt_q   <= dlen;
                  st_q    <= ST_READ;
                end
                OP_WRITE: st_q <= ST_DATA;
                OP_ERASE: begin
                  if (prog_ok) begin
                    aop_q   <= AOP_WORD;
                    wdata_q <= 16'hFFFF;
                    start_q <= 1'b1;
                    st_q    <= ST_PROG;
                  end else st_q <= ST_DONE;
                end
                default: begin
                  unique case (ext)
                    EX_WEN:   begin wen_q <= 1'b1; st_q <= ST_DONE; end
                    EX_WDIS:  begin wen_q <= 1'b0; st_q <= ST_DONE; end
                    EX_WRALL: st_q <= ST_DATA;
                    default: begin
                      if (prog_ok) begin
                        aop_q   <= AOP_ALL;
                        wdata_q <= 16'hFFFF;
                        start_q <= 1'b1;
                        st_q    <= ST_PROG;
                      end else st_q <= ST_DONE;
                    end
                  endcase
                end
              endcase
            end else cnt_q <= cnt_q + 5'd1;
          end
          ST_DATA: if (rise_i) begin
            data_q <= data_nxt;
            if (cnt_q == dlen - 5'd1) begin
              if (prog_ok) begin
                aop_q   <= (opc_q == OP_EXT) ? AOP_ALL : AOP_WORD;
                wdata_q <= data_nxt;
                start_q <= 1'b1;
                st_q    <= ST_PROG;
              end else st_q <= ST_DONE;
            end else cnt_q <= cnt_q + 5'd1;
          end
          ST_READ: if (rise_i) begin
            if (cnt_q == '0) st_q <= ST_DONE;
            else begin
              out_q   <= rd_sr_q[15];
              rd_sr_q <= {rd_sr_q[14:0], 1'b0};
              cnt_q   <= cnt_q - 5'd1;
            end
          end
          ST_PROG: if (done_i) st_q <= cs_i ? ST_STATUS : ST_IDLE;
          default: ;
        endcase
      end
    end
  end

  assign aop_o   = aop_q;
  assign addr_o  = (st_q == ST_ADDR) ? addr_nxt : addr_q;
  assign wdata_o = wdata_q;
  assign start_o = start_q;
  assign wen_o   = wen_q;
  assign st_o    = st_q;
  assign do_oe_o = cs_i && (st_q == ST_READ || st_q == ST_PROG || st_q == ST_STATUS);
  assign do_o    = (st_q == ST_READ) ? out_q : (st_q == ST_STATUS);
endmodule

// File: rtl/serial_eeprom.sv
module serial_eeprom
  import se_pkg::*;
#(
  parameter int BYTES       = 1024,
  parameter int PROG_CYCLES = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic di_i,
  input  logic org_i,
  input  logic pe_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int AW = $clog2(BYTES);

  logic [2:0]    pins_s;
  logic          cs_s, sclk_s, di_s, sclk_d, rise;
  logic          start, busy, done, wen;
  aop_e          aop;
  st_e           st;
  logic [AW-1:0] addr;
  logic [15:0]   wdata, rdata;

  se_sync #(.W(3)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .d_i   ({cs_i, sclk_i, di_i}), .q_o(pins_s)
  );
  assign {cs_s, sclk_s, di_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_s;
  end
  assign rise = sclk_s && !sclk_d;

  se_ctrl #(.AW(AW)) u_ctrl (
    .clk_i  (clk_i), .rst_ni(rst_ni),
    .cs_i   (cs_s),  .rise_i(rise), .di_i(di_s),
    .org_i  (org_i), .pe_i(pe_i),   .done_i(done),
    .rdata_i(rdata), .aop_o(aop),   .addr_o(addr),
    .wdata_o(wdata), .start_o(start), .wen_o(wen),
    .st_o   (st),    .do_o(do_o),   .do_oe_o(do_oe_o)
  );

  se_busy_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .busy_o(busy), .done_o(done)
  );

  se_array #(.BYTES(BYTES), .AW(AW)) u_array (
    .clk_i (clk_i), .org_i(org_i), .op_i(aop),
    .addr_i(addr),  .wdata_i(wdata), .rdata_o(rdata)
  );
endmodule

// File: rtl/serial_eeprom_chk.sv
module serial_eeprom_chk
  import se_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic cs_s,
  input logic pe_i,
  input logic do_o,
  input logic do_oe_o,
  input st_e  st,
  input aop_e aop,
  input logic wen,
  input logic busy
);
  assert_oe_needs_cs_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_oe_o |-> cs_s);

  assert_oe_states_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_oe_o |-> (st == ST_READ || st == ST_PROG || st == ST_STATUS));

  assert_busy_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_PROG && do_oe_o) |-> !do_o);

  assert_prog_starts_timer_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aop != AOP_NONE) |=> (st == ST_PROG && busy));

  assert_needs_wen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aop != AOP_NONE) |-> wen);

  assert_needs_pe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aop != AOP_NONE) |-> $past(pe_i));

  assert_dummy_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_READ && $past(st) != ST_READ) |-> !do_o);

  assert_busy_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_PROG) |=> (st == ST_PROG || st == ST_STATUS || st == ST_IDLE));
endmodule

bind serial_eeprom serial_eeprom_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_s   (cs_s),
  .pe_i   (pe_i),
  .do_o   (do_o),
  .do_oe_o(do_oe_o),
  .st     (st),
  .aop    (aop),
  .wen    (wen),
  .busy   (busy)
);

// File: tb/serial_eeprom_tb.sv
`timescale 1ns/100ps
module serial_eeprom_tb;
  localparam int PROG_CYCLES = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, di = 1'b0, org = 1'b1, pe = 1'b1;
  logic dout, doe;
  int   n_chk = 0, n_fail = 0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  serial_eeprom #(.BYTES(1024), .PROG_CYCLES(PROG_CYCLES)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .di_i(di),
    .org_i(org), .pe_i(pe), .do_o(dout), .do_oe_o(doe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int alen();
    return org ? 9 : 10;
  endfunction

  function automatic int dlen();
    return org ? 16 : 8;
  endfunction

  task automatic tick(input logic b);
    di = b;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) tick(v[i]);
  endtask

  task automatic cs_up();
    @(negedge clk);
    cs = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_down();
    cs = 1'b0; di = 1'b0; sclk = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic hdr(input logic [1:0] op, input logic [15:0] a);
    tick(1'b1);
    send({14'd0, op}, 2);
    send(a, alen());
  endtask

  task automatic wait_ready(input string req, input bit timed);
    int n = 0;
    chk({req, " busy shown"}, {doe, dout}, {1'b1, 1'b0});
    while (!(doe && dout) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk({req, " ready shown"}, {doe, dout}, {1'b1, 1'b1});
    if (timed)
      chk("R10 busy length", (n >= PROG_CYCLES - 8 && n <= PROG_CYCLES + 8), 1);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d, input string req);
    cs_up(); hdr(2'b01, a); send(d, dlen());
    wait_ready(req, 1'b1);
    cs_down();
    chk("R12 oe off after cs low", doe, 0);
  endtask

  task automatic blocked_write(input logic [15:0] a, input logic [15:0] d, input string req);
    cs_up(); hdr(2'b01, a); send(d, dlen());
    chk({req, " no busy"}, doe, 0);
    cs_down();
  endtask

  task automatic ext(input logic [1:0] code);
    cs_up(); hdr(2'b00, {14'd0, code} << (alen() - 2)); cs_down();
  endtask

  task automatic do_read(input logic [15:0] a, output logic [15:0] v);
    v = '0;
    cs_up(); hdr(2'b10, a);
    chk("R3 dummy zero", {doe, dout}, {1'b1, 1'b0});
    for (int i = 0; i < dlen(); i++) begin
      tick(1'b0);
      v = {v[14:0], dout};
      chk("R3 oe during read", doe, 1);
    end
    tick(1'b0);
    chk("R3 release after last bit", doe, 0);
    cs_down();
  endtask

  task automatic read_chk(input logic [15:0] a, input logic [15:0] e, input string req);
    logic [15:0] v;
    do_read(a, v);
    chk(req, v, e);
  endtask

  task automatic t_reset();
    chk("R12 reset oe", doe, 0);
  endtask

  task automatic t_protect();
    org = 1'b1;
    blocked_write(16'd5, 16'h1234, "R7 disabled at reset");
    ext(2'b11);
    do_write(16'd5, 16'hA5C3, "R7 after enable");
    read_chk(16'd5, 16'hA5C3, "R7 written after enable");
    ext(2'b00);
    blocked_write(16'd5, 16'h0000, "R7 disabled again");
    read_chk(16'd5, 16'hA5C3, "R7 kept after disable");
    ext(2'b11);
  endtask

  task automatic t_x16();
    do_write(16'd0, 16'h8001, "R2 x16 addr 0");
    do_write(16'd511, 16'h7FFE, "R2 x16 addr 511");
    do_write(16'h155, 16'h3C96, "R4 x16 mid");
    read_chk(16'd0, 16'h8001, "R2 x16 read 0");
    read_chk(16'd511, 16'h7FFE, "R2 x16 read 511");
    read_chk(16'h155, 16'h3C96, "R4 x16 read mid");
  endtask

  task automatic t_x8();
    org = 1'b0;
    read_chk(16'd10, 16'h00C3, "R4 low byte of word 5");
    read_chk(16'd11, 16'h00A5, "R4 high byte of word 5");
    do_write(16'h3FF, 16'h005A, "R4 x8 write top");
    read_chk(16'h3FF, 16'h005A, "R4 x8 read top");
    org = 1'b1;
    read_chk(16'd511, 16'h5AFE, "R4 x8 byte seen in x16 word");
  endtask

  task automatic t_erase();
    cs_up(); hdr(2'b11, 16'd0);
    wait_ready("R5 erase", 1'b1);
    cs_down();
    read_chk(16'd0, 16'hFFFF, "R5 erased word");
    read_chk(16'h155, 16'h3C96, "R5 neighbour untouched");
  endtask

  task automatic t_pe();
    pe = 1'b0;
    repeat (2) @(negedge clk);
    blocked_write(16'h155, 16'h0000, "R8 write blocked");
    cs_up(); hdr(2'b11, 16'h155);
    chk("R8 erase blocked", doe, 0);
    cs_down();
    pe = 1'b1;
    repeat (2) @(negedge clk);
    read_chk(16'h155, 16'h3C96, "R8 data kept");
  endtask

  task automatic t_trunc();
    cs_up(); hdr(2'b01, 16'h155); send(16'h001F, 5);
    cs_down();
    chk("R9 no busy after cut", doe, 0);
    cs_up(); hdr(2'b01, 16'h155); send(16'hFFFF, 15);
    cs_down();
    read_chk(16'h155, 16'h3C96, "R9 cut frame discarded");
  endtask

  task automatic t_start();
    logic [15:0] v;
    sclk = 1'b0; di = 1'b1;
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b1; repeat (4) @(negedge clk);
      sclk = 1'b0; repeat (4) @(negedge clk);
    end
    chk("R1 nothing with cs low", doe, 0);
    cs_up();
    tick(1'b0); tick(1'b0); tick(1'b0);
    chk("R1 zeros do not start", doe, 0);
    hdr(2'b10, 16'd5);
    chk("R1 start after zeros", {doe, dout}, {1'b1, 1'b0});
    v = '0;
    for (int i = 0; i < 16; i++) begin
      tick(1'b0);
      v = {v[14:0], dout};
    end
    chk("R1 read after leading zeros", v, 16'hA5C3);
    cs_down();
  endtask

  task automatic t_busy();
    cs_up(); hdr(2'b01, 16'd7); send(16'h0F0F, 16);
    chk("R10 busy at start", {doe, dout}, {1'b1, 1'b0});
    repeat (10) @(negedge clk);
    cs = 1'b0; repeat (4) @(negedge clk);
    chk("R12 oe off during busy with cs low", doe, 0);
    cs = 1'b1; repeat (4) @(negedge clk);
    chk("R10 busy after cs back", {doe, dout}, {1'b1, 1'b0});
    hdr(2'b00, 16'd0);
    chk("R11 frame during busy ignored", {doe, dout}, {1'b1, 1'b0});
    wait_ready("R10 ready", 1'b0);
    cs_down();
    do_write(16'd8, 16'hC0DE, "R11 enable survived");
    read_chk(16'd7, 16'h0F0F, "R11 first write");
    read_chk(16'd8, 16'hC0DE, "R11 second write");
  endtask

  task automatic t_all();
    cs_up(); hdr(2'b00, 16'h0080); send(16'h1E2D, 16);
    wait_ready("R6 write-all", 1'b1);
    cs_down();
    read_chk(16'd0, 16'h1E2D, "R6 write-all word 0");
    read_chk(16'd300, 16'h1E2D, "R6 write-all word 300");
    read_chk(16'd511, 16'h1E2D, "R6 write-all word 511");
    org = 1'b0;
    read_chk(16'd1, 16'h001E, "R6 write-all odd byte");
    org = 1'b1;
    cs_up(); hdr(2'b00, 16'h0100);
    wait_ready("R6 erase-all", 1'b1);
    cs_down();
    read_chk(16'd0, 16'hFFFF, "R6 erase-all word 0");
    read_chk(16'd256, 16'hFFFF, "R6 erase-all word 256");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_protect();
    t_x16();
    t_x8();
    t_erase();
    t_pe();
    t_trunc();
    t_start();
    t_busy();
    t_all();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule